// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Sequencer

This block sits beside a processor core and decides, at each instruction boundary, whether an interrupt is taken and which 8-bit type number the core should use to fetch its vector. It watches three sources. The first is an overflow trap, raised by a trap-on-overflow instruction when the overflow flag is set. The second is a non-maskable interrupt pin. The third is a maskable request line that is gated by an interrupt-enable flag, which this block holds.

The two internal sources produce a fixed type number at once. A maskable request starts a handshake with an external interrupt controller. The active-low acknowledge pin is pulsed low twice, with idle clocks between the pulses. The controller uses the first pulse to prepare. The block reads the type byte from the data bus during the second pulse. In every case the result is a one-clock take pulse and a type number, and the enable flag is cleared so that maskable interrupts do not nest. Vector fetch and stack pushes belong to the core.

Top module: `int_ack_seq`

## Requirements
- R1: After reset, inta_n is 1, take_int is 0, int_type is 0 and ie_flag is 0.
- R2: Decisions are made only in a cycle where instr_last is 1 and no handshake is running. Without such a cycle, no request causes take_int or an acknowledge pulse.
- R3: A 0-to-1 transition on nmi_pin is latched and held until it is serviced, even if the pin falls again. It is serviced at the next boundary regardless of ie_flag, with int_type = 2. A pin held high does not trigger a second time.
- R4: When an NMI is pending at a boundary, it is taken instead of a maskable request, and inta_n stays 1.
- R5: A maskable request on irq_req at a boundary is honoured only when ie_flag is 1. Otherwise nothing happens.
- R6: A honoured maskable request drives inta_n low for PULSE_W clocks, high for GAP_W clocks (at least 1), then low for PULSE_W clocks. The first low clock is the cycle right after the boundary.
- R7: The type number is the value on data_bus in the final clock of the second low pulse, passed through unchanged (any of 0..255). take_int rises in the clock after the second pulse ends. Bus values seen during the first pulse are not used.
- R8: At a boundary with trap_ovf_op = 1, an interrupt of type 4 is taken only if ovf_flag = 1. The trap outranks a pending NMI, which stays pending and is taken at a later boundary.
- R9: ie_set sets ie_flag and ie_clr clears it, with clear winning. Taking any interrupt clears ie_flag in the cycle after the boundary, overriding ie_set.
- R10: For trap and NMI, take_int is high for exactly the one cycle after the boundary, and int_type then holds the type.
- R11: Boundaries that occur while a handshake runs start nothing. An NMI edge arriving then is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| irq_req | input | 1 | Maskable interrupt request level |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| ovf_flag | input | 1 | Core overflow flag |
| trap_ovf_op | input | 1 | Trap-on-overflow instruction is finishing |
| instr_last | input | 1 | Last clock of the current instruction |
| data_bus | input | 8 | Type byte from the external controller |
| take_int | output | 1 | One-cycle pulse: interrupt taken |
| int_type | output | 8 | Type number of the taken interrupt |
| inta_n | output | 1 | Active-low acknowledge to the controller |
| ie_flag | output | 1 | Interrupt-enable flag |

## Verification
On every cycle, the assertions check the decision at each boundary: the priority between trap, NMI and maskable request, the fixed types 2 and 4, the block on maskable requests when the flag is clear, the clearing of the enable flag, and that nothing starts away from a boundary. They also check that the byte captured at the end of the second pulse is what appears on int_type. The bench scenarios show what those single-step properties cannot. These are the full low/high/low shape of the acknowledge waveform, an NMI edge that is held across many idle cycles, a pin held high that does not trigger again, and a deferred NMI that is served after a trap. The scenarios also show that a first-pulse bus value is discarded.

// File: rtl/iack_pkg.sv
package iack_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_ACK1,
        HS_GAP,
        HS_ACK2
    } hs_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_NMI,
        SRC_IRQ
    } src_e;

    localparam logic [7:0] NMI_TYPE = 8'd2;
    localparam logic [7:0] OVF_TYPE = 8'd4;

endpackage

// File: rtl/iack_nmi_latch.sv
module iack_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic serviced,
    output logic pending
);

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_t;

    nmi_t q, d;

    always_comb begin
        d      = q;
        d.prev = nmi_pin;
        if (serviced) d.pend = 1'b0;
        if (nmi_pin && !q.prev) d.pend = 1'b1;  // a fresh edge survives a same-cycle service
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev <= 1'b1;   // a pin already high at reset is not an edge
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pending = q.pend;

    // R3: a latched request stays until it is serviced
    p_nmi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !serviced |=> pending);

endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter
    import iack_pkg::*;
(
    input  logic boundary,
    input  logic trap_hit,
    input  logic nmi_pend,
    input  logic irq_ok,
    output src_e sel
);

    always_comb begin
        sel = SRC_NONE;
        if (boundary) begin
            if (trap_hit)      sel = SRC_TRAP;
            else if (nmi_pend) sel = SRC_NMI;
            else if (irq_ok)   sel = SRC_IRQ;
        end
    end

endmodule

// File: rtl/iack_handshake.sv
module iack_handshake
    import iack_pkg::*;
#(
    parameter int PULSE_W = 2,
    parameter int GAP_W   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_irq,
    input  logic       fixed_take,
    input  logic [7:0] fixed_type,
    input  logic [7:0] data_bus,
    output logic       busy,
    output logic       inta_n,
    output logic       take,
    output logic [7:0] vtype
);

    localparam int MAX_W = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
    localparam int CNT_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_W - 1);
    localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_W - 1);

    typedef struct packed {
        hs_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             take;
        logic [7:0]       vtype;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d      = q;
        d.take = 1'b0;
        case (q.state)
            HS_IDLE: begin
                if (start_irq) begin
                    d.state = HS_ACK1;
                    d.cnt   = '0;
                end else if (fixed_take) begin
                    d.take  = 1'b1;
                    d.vtype = fixed_type;
                end
            end
            HS_ACK1: begin
                if (q.cnt == PULSE_END) begin
                    d.state = HS_GAP;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            HS_GAP: begin
                if (q.cnt == GAP_END) begin
                    d.state = HS_ACK2;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            HS_ACK2: begin
                if (q.cnt == PULSE_END) begin
                    d.state = HS_IDLE;
                    d.cnt   = '0;
                    d.take  = 1'b1;
                    d.vtype = data_bus;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= HS_IDLE;
            q.cnt   <= '0;
            q.take  <= 1'b0;
            q.vtype <= 8'd0;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.state != HS_IDLE);
    assign inta_n = !((q.state == HS_ACK1) || (q.state == HS_ACK2));
    assign take   = q.take;
    assign vtype  = q.vtype;

    // R7: the byte on the bus in the last low clock of the second pulse is delivered
    p_capture_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == HS_ACK2) && (q.cnt == PULSE_END)
        |=> take && (vtype == $past(data_bus)));

    // R6: an accepted request pulls the acknowledge low in the next cycle
    p_ack_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq && !busy |=> !inta_n);

endmodule

// File: rtl/int_ack_seq.sv
module int_ack_seq
    import iack_pkg::*;
#(
    parameter int PULSE_W = 2,
    parameter int GAP_W   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_pin,
    input  logic       irq_req,
    input  logic       ie_set,
    input  logic       ie_clr,
    input  logic       ovf_flag,
    input  logic       trap_ovf_op,
    input  logic       instr_last,
    input  logic [7:0] data_bus,
    output logic       take_int,
    output logic [7:0] int_type,
    output logic       inta_n,
    output logic       ie_flag
);

    typedef struct packed {
        logic ie;
    } top_t;

    top_t q, d;
    logic busy;
    logic nmi_pend;
    logic boundary;
    src_e sel;

    assign boundary = instr_last && !busy;

    iack_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_pin  (nmi_pin),
        .serviced (sel == SRC_NMI),
        .pending  (nmi_pend)
    );

    iack_arbiter u_arb (
        .boundary (boundary),
        .trap_hit (trap_ovf_op && ovf_flag),
        .nmi_pend (nmi_pend),
        .irq_ok   (irq_req && q.ie),
        .sel      (sel)
    );

    iack_handshake #(
        .PULSE_W (PULSE_W),
        .GAP_W   (GAP_W)
    ) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_irq  (sel == SRC_IRQ),
        .fixed_take ((sel == SRC_TRAP) || (sel == SRC_NMI)),
        .fixed_type ((sel == SRC_TRAP) ? OVF_TYPE : NMI_TYPE),
        .data_bus   (data_bus),
        .busy       (busy),
        .inta_n     (inta_n),
        .take       (take_int),
        .vtype      (int_type)
    );

    always_comb begin
        d = q;
        if (ie_set) d.ie = 1'b1;
        if (ie_clr) d.ie = 1'b0;
        if (sel != SRC_NONE) d.ie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.ie <= 1'b0;
        else        q <= d;
    end

    assign ie_flag = q.ie;

    // R2: nothing starts away from an instruction boundary
    p_only_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_last && !busy |=> !take_int && inta_n);

    // R3: a pending NMI without a trap is taken as type 2
    p_nmi_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && nmi_pend && !(trap_ovf_op && ovf_flag)
        |=> take_int && (int_type == 8'd2));

    // R4: NMI wins over the maskable request, no acknowledge pulse
    p_nmi_over_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && nmi_pend && irq_req |=> inta_n);

    // R5: maskable request blocked while the enable flag is clear
    p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && irq_req && !ie_flag && !nmi_pend && !trap_ovf_op
        |=> inta_n && !take_int);

    // R8: overflow trap gives type 4
    p_trap_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && trap_ovf_op && ovf_flag |=> take_int && (int_type == 8'd4));

    // R9: taking any interrupt leaves the enable flag clear
    p_ie_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SRC_NONE) |=> !ie_flag);

endmodule

// File: tb/tb_int_ack_seq.sv
module tb_int_ack_seq;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 2;
    localparam int GW = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       irq_req = 1'b0;
    logic       ie_set = 1'b0;
    logic       ie_clr = 1'b0;
    logic       ovf_flag = 1'b0;
    logic       trap_ovf_op = 1'b0;
    logic       instr_last = 1'b0;
    logic [7:0] data_bus = 8'd0;
    logic       take_int;
    logic [7:0] int_type;
    logic       inta_n;
    logic       ie_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_ack_seq #(.PULSE_W(PW), .GAP_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_req(irq_req),
        .ie_set(ie_set), .ie_clr(ie_clr), .ovf_flag(ovf_flag),
        .trap_ovf_op(trap_ovf_op), .instr_last(instr_last), .data_bus(data_bus),
        .take_int(take_int), .int_type(int_type), .inta_n(inta_n), .ie_flag(ie_flag)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic boundary();
        instr_last = 1'b1;
        tick();
        instr_last = 1'b0;
    endtask

    task automatic set_ie();
        ie_set = 1'b1;
        tick();
        ie_set = 1'b0;
    endtask

    task automatic idle_check(input int n, input string what);
        for (int i = 0; i < n; i++) begin
            check({what, " take_int"}, take_int, 0);
            check({what, " inta_n"}, inta_n, 1);
            tick();
        end
    endtask

    // called at the first negedge after a boundary that started a handshake
    task automatic ack_seq(input logic [7:0] v2, input string what);
        for (int i = 0; i < 2*PW + GW; i++) begin
            check({what, " R6 inta_n shape"}, inta_n, (i < PW || i >= PW + GW) ? 0 : 1);
            check({what, " R6 no early take"}, take_int, 0);
            if (i == 0) instr_last = 1'b1;       // R11: boundary inside handshake
            if (i == 1) instr_last = 1'b0;
            if (i == PW) data_bus = v2;
            tick();
        end
        check({what, " R7 take"}, take_int, 1);
        check({what, " R7 type"}, int_type, v2);
        tick();
        check({what, " R10 take drops"}, take_int, 0);
        check({what, " R11 no restart"}, inta_n, 1);
    endtask

    task automatic t_reset();
        check("R1 inta_n", inta_n, 1);
        check("R1 take_int", take_int, 0);
        check("R1 int_type", int_type, 0);
        check("R1 ie_flag", ie_flag, 0);
    endtask

    task automatic t_no_boundary();
        set_ie();
        check("R9 ie_set", ie_flag, 1);
        irq_req = 1'b1;
        idle_check(5, "R2 off-boundary");
        irq_req = 1'b0;
    endtask

    task automatic t_maskable();
        irq_req = 1'b1;
        data_bus = 8'h11;
        boundary();
        check("R9 ie cleared by maskable", ie_flag, 0);
        ack_seq(8'hC7, "R7 C7");
        irq_req = 1'b0;
    endtask

    task automatic t_masked();
        irq_req = 1'b1;
        boundary();
        idle_check(4, "R5 masked");
        irq_req = 1'b0;
    endtask

    task automatic t_nmi_edge();
        set_ie();
        nmi_pin = 1'b1;
        tick();
        nmi_pin = 1'b0;
        idle_check(6, "R3 nmi held");
        boundary();
        check("R3 nmi take", take_int, 1);
        check("R3 nmi type", int_type, 2);
        check("R9 ie cleared by nmi", ie_flag, 0);
        check("R4 no ack for nmi", inta_n, 1);
        tick();
        check("R10 nmi pulse one cycle", take_int, 0);
    endtask

    task automatic t_nmi_level();
        nmi_pin = 1'b1;
        tick();
        boundary();
        check("R3 level first take", take_int, 1);
        tick();
        boundary();
        check("R3 level no retrigger", take_int, 0);
        nmi_pin = 1'b0;
        tick();
    endtask

    task automatic t_nmi_priority();
        set_ie();
        irq_req = 1'b1;
        nmi_pin = 1'b1;
        tick();
        nmi_pin = 1'b0;
        boundary();
        check("R4 nmi wins take", take_int, 1);
        check("R4 nmi wins type", int_type, 2);
        check("R4 inta idle", inta_n, 1);
        tick();
        boundary();
        check("R5 blocked after nmi", inta_n, 1);
        check("R5 blocked take", take_int, 0);
        set_ie();
        data_bus = 8'hAA;
        boundary();
        ack_seq(8'h20, "R7 type32");
        set_ie();
        data_bus = 8'h00;
        boundary();
        ack_seq(8'hFF, "R7 type255");
        irq_req = 1'b0;
    endtask

    task automatic t_trap();
        trap_ovf_op = 1'b1;
        ovf_flag = 1'b1;
        boundary();
        trap_ovf_op = 1'b0;
        check("R8 trap take", take_int, 1);
        check("R8 trap type", int_type, 4);
        tick();
        check("R10 trap pulse one cycle", take_int, 0);
        ovf_flag = 1'b0;
        trap_ovf_op = 1'b1;
        boundary();
        trap_ovf_op = 1'b0;
        idle_check(3, "R8 no overflow");
        // trap outranks a pending NMI, which is served afterwards
        nmi_pin = 1'b1;
        tick();
        nmi_pin = 1'b0;
        trap_ovf_op = 1'b1;
        ovf_flag = 1'b1;
        boundary();
        trap_ovf_op = 1'b0;
        ovf_flag = 1'b0;
        check("R8 trap over nmi type", int_type, 4);
        tick();
        tick();
        boundary();
        check("R8 deferred nmi take", take_int, 1);
        check("R8 deferred nmi type", int_type, 2);
        tick();
    endtask

    task automatic t_ie_rules();
        ie_set = 1'b1;
        ie_clr = 1'b1;
        tick();
        ie_set = 1'b0;
        ie_clr = 1'b0;
        check("R9 clear wins over set", ie_flag, 0);
        ie_set = 1'b1;
        trap_ovf_op = 1'b1;
        ovf_flag = 1'b1;
        boundary();
        ie_set = 1'b0;
        trap_ovf_op = 1'b0;
        ovf_flag = 1'b0;
        check("R9 take wins over set", ie_flag, 0);
        tick();
    endtask

    task automatic t_nmi_during_ack();
        set_ie();
        irq_req = 1'b1;
        boundary();
        irq_req = 1'b0;
        nmi_pin = 1'b1;
        tick();
        nmi_pin = 1'b0;
        for (int i = 1; i < 2*PW + GW; i++) tick();
        check("R11 handshake still completes", take_int, 1);
        tick();
        boundary();
        check("R11 nmi edge kept", take_int, 1);
        check("R11 nmi type", int_type, 2);
        tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_no_boundary();
        t_maskable();
        t_masked();
        t_nmi_edge();
        t_nmi_level();
        t_nmi_priority();
        t_trap();
        t_ie_rules();
        t_nmi_during_ack();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule